// File: doc/BRIEF.md
# Framed 16-bit Serial Slave Port

This block is the slave end of a synchronous serial link to a DSP or microcontroller. The master supplies the bit clock, an active-low frame sync and serial data in. Each frame swaps one 16-bit word in each direction, most significant bit first. The word to send is taken from a parallel input when a frame begins. The word received appears on a parallel output together with a one-cycle strobe.

All serial inputs pass through two flip-flop stages into a faster system clock, and bit clock edges are found by comparing successive synchronised samples. The bit clock must run at no more than a quarter of the system clock rate.

The port has two framing schemes:
- **Level framing:** the frame runs for as long as sync is low. Sync may also be held low permanently, and then every group of 16 bits is one frame.
- **Edge framing:** a sync falling edge starts the frame, and the port counts 16 bits by itself.

A polarity input chooses which clock edge shifts data out and which edge samples data in. The serial output is split into a data bit and an enable, so the tristate buffer stays at the chip level.

Top module: `serial_word_port`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `dout_en` and `rx_valid` are 0 and `rx_word` is 0.
- R2: `mode` = 2'b01 selects edge framing. Every other value (00, 10, 11) selects level framing.
- R3: In level framing a frame begins when synchronised sync is low and no frame is running. After 16 sample edges the word is delivered. If sync is still low at that point, the next 16 bits form a new frame, and `tx_word` is loaded again at that moment.
- R4: `tx_word` is captured when a frame starts. `dout` is 0 until the first shift edge. Successive shift edges then present `tx_word` bit 15, bit 14, and so on down to bit 0.
- R5: `din` is sampled on sample edges, and the first bit sampled becomes bit 15 of the result. `rx_word` changes only together with a one-cycle `rx_valid` pulse after the 16th sample.
- R6: With `pol` = 0, shift edges are falling edges of `sclk` and sample edges are rising edges. With `pol` = 1 the two roles are swapped.
- R7: In edge framing a frame starts on a sync falling edge and ends after 16 sample edges, whatever sync does in between. Clock edges after that are ignored until the next falling edge.
- R8: In edge framing, a sync falling edge during a frame abandons that frame without `rx_valid`, reloads `tx_word` and restarts from bit 15.
- R9: In level framing, sync going high before the 16th sample ends the frame without `rx_valid`. The next frame restarts at bit 15.
- R10: `dout_en` is 1 exactly when synchronised sync is low and either level framing is selected or an edge-framed frame is running.
- R11: A pin change takes effect on the third rising system clock edge after it. For example, `rx_valid` is high in the cycle after the third rising edge that follows the 16th sample edge at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing select: 01 edge framing, any other value level framing |
| pol | input | 1 | Clock edge polarity select |
| sclk | input | 1 | Serial bit clock from the master |
| sync_n | input | 1 | Active-low frame sync from the master |
| din | input | 1 | Serial data from the master |
| tx_word | input | 16 | Word to transmit, captured at frame start |
| dout | output | 1 | Serial data to the master |
| dout_en | output | 1 | Enable for the external tristate buffer on `dout` |
| rx_word | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
The bench targets the following corner cases:
- **Back-to-back frames with sync held low.** A port that skipped the `tx_word` reload would send a stale word in the second frame. One that waited for a sync edge would deliver only one word.
- **Edge framing with sync rising mid-frame, or never rising at all.** A design that treated sync as a level would lose the word, or keep `dout_en` high after the count.
- **A restart in edge framing and an early sync rise in level framing.** A design with a stale bit counter would deliver a spurious or misaligned word.
- **Reserved mode codes and the polarity swap.** These catch a decoder that confuses the framing schemes, and edge roles that are not exchanged.

// File: rtl/serial_word_port.sv
module serial_word_port #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pol,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  input  logic [WORD_W-1:0] tx_word,
  output logic              dout,
  output logic              dout_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sclk_ff, sync_ff, din_ff;
  logic sclk_d, sync_d;
  logic busy;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] txsr, rxsr;
  logic dout_q;

  wire sclk_s = sclk_ff[SYNC_STAGES-1];
  wire sync_s = sync_ff[SYNC_STAGES-1];
  wire din_s  = din_ff[SYNC_STAGES-1];
  wire level  = (mode != 2'b01);
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;
  wire shift_edge  = pol ? rise : fall;
  wire sample_edge = pol ? fall : rise;
  wire start  = (sync_d & ~sync_s) | (level & ~sync_s & ~busy);
  wire [WORD_W-1:0] rx_next = {rxsr[WORD_W-2:0], din_s};

  assign dout    = dout_q;
  assign dout_en = ~sync_s & (level | busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_ff  <= '0;
      sync_ff  <= '1;
      din_ff   <= '0;
      sclk_d   <= 1'b0;
      sync_d   <= 1'b1;
      busy     <= 1'b0;
      cnt      <= '0;
      txsr     <= '0;
      rxsr     <= '0;
      dout_q   <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sclk_ff  <= {sclk_ff[SYNC_STAGES-2:0], sclk};
      sync_ff  <= {sync_ff[SYNC_STAGES-2:0], sync_n};
      din_ff   <= {din_ff[SYNC_STAGES-2:0], din};
      sclk_d   <= sclk_s;
      sync_d   <= sync_s;
      rx_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        txsr   <= tx_word;
        dout_q <= 1'b0;
      end else if (busy && level && sync_s) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (shift_edge) begin
          dout_q <= txsr[WORD_W-1];
          txsr   <= {txsr[WORD_W-2:0], 1'b0};
        end
        if (sample_edge) begin
          rxsr <= rx_next;
          if (cnt == LAST_BIT) begin
            rx_word  <= rx_next;
            rx_valid <= 1'b1;
            cnt      <= '0;
            if (level) txsr <= tx_word;
            else       busy <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  valid_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample_edge));

  // R7
  edge_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(level) && $fell(busy)) |-> rx_valid);

  // R4
  dout_moves_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> $past(shift_edge || start));
endmodule

// File: tb/test_serial_word_port.sv
module test_serial_word_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic pol = 1'b0, sclk = 1'b1, sync_n = 1'b1, din = 1'b0;
  logic [15:0] tx_word = '0;
  wire dout, dout_en, rx_valid;
  wire [15:0] rx_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_port i_serial_word_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pol(pol), .sclk(sclk),
    .sync_n(sync_n), .din(din), .tx_word(tx_word), .dout(dout),
    .dout_en(dout_en), .rx_word(rx_word), .rx_valid(rx_valid));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: input history, newest at index 0
  bit [3:0] h_sclk, h_sync, h_din;
  bit m_busy, m_dout, m_valid, m_en, lvl, shf, smp, rs, fl;
  int m_cnt;
  bit [15:0] m_tx, m_rx, m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_sclk = '0; h_sync = '1; h_din = '0;
      m_busy = 0; m_dout = 0; m_valid = 0; m_en = 0;
      m_cnt = 0; m_tx = 0; m_rx = 0; m_word = 0;
    end else begin
      h_sclk = {h_sclk[2:0], sclk};
      h_sync = {h_sync[2:0], sync_n};
      h_din  = {h_din[2:0], din};
      lvl = (mode != 2'b01);
      rs  = h_sclk[2] && !h_sclk[3];
      fl  = !h_sclk[2] && h_sclk[3];
      shf = pol ? rs : fl;
      smp = pol ? fl : rs;
      m_valid = 0;
      if ((h_sync[3] && !h_sync[2]) || (lvl && !h_sync[2] && !m_busy)) begin
        m_busy = 1; m_cnt = 0; m_tx = tx_word; m_dout = 0;
      end else if (m_busy && lvl && h_sync[2]) begin
        m_busy = 0;
      end else if (m_busy) begin
        if (shf) begin m_dout = m_tx[15]; m_tx = m_tx << 1; end
        if (smp) begin
          m_rx = {m_rx[14:0], h_din[2]};
          m_cnt++;
          if (m_cnt == 16) begin
            m_word = m_rx; m_valid = 1; m_cnt = 0;
            if (lvl) m_tx = tx_word; else m_busy = 0;
          end
        end
      end
      m_en = !h_sync[1] && (lvl || m_busy);
    end
  end

  int vcount = 0;
  logic [15:0] vlast = '0, got = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R10 dout_en per cycle", 32'(dout_en), 32'(m_en));
      if (m_en) check("R4 dout per cycle", 32'(dout), 32'(m_dout));
      check("R11 rx_valid timing", 32'(rx_valid), 32'(m_valid));
      check("R5 rx_word per cycle", 32'(rx_word), 32'(m_word));
      if (rx_valid) begin vcount++; vlast = rx_word; end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [15:0] w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      sclk = pol; din = w[15-i];
      wclk(HALF);
      got[15-i] = dout;
      sclk = !pol;
      wclk(HALF);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    wclk(5);
    check("R1 reset dout_en", 32'(dout_en), 0);
    check("R1 reset rx_valid", 32'(rx_valid), 0);
    rst_n = 1;
    wclk(1);
    check("R1 after reset dout_en", 32'(dout_en), 0);
    check("R1 after reset rx_word", 32'(rx_word), 0);

    // level framing, pol 0
    tx_word = 16'hA5C3; vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'h3C96, 0, 16); wclk(4); sync_n = 1; wclk(8);
    check("R3 level frame count", vcount, 1);
    check("R5 level rx word", 32'(vlast), 32'h3C96);
    check("R4 level tx word", 32'(got), 32'hA5C3);

    // polarity swapped
    pol = 1; sclk = 0; wclk(8);
    tx_word = 16'h81E7; vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'h6D02, 0, 16); wclk(4); sync_n = 1; wclk(8);
    check("R6 pol1 count", vcount, 1);
    check("R6 pol1 rx word", 32'(vlast), 32'h6D02);
    check("R6 pol1 tx word", 32'(got), 32'h81E7);

    // sync held low, back-to-back frames
    pol = 0; sclk = 1; wclk(8);
    tx_word = 16'h1234; vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'hF00D, 0, 8); tx_word = 16'hABCD; bits(16'hF00D, 8, 8);
    check("R3 tied-low first tx", 32'(got), 32'h1234);
    bits(16'h0FF1, 0, 16);
    check("R3 tied-low reload tx", 32'(got), 32'hABCD);
    check("R3 tied-low count", vcount, 2);
    check("R5 tied-low rx word", 32'(vlast), 32'h0FF1);
    sync_n = 1; wclk(8);

    // reserved mode code behaves as level framing
    mode = 2'b10; vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'h1111, 0, 16); bits(16'h2222, 0, 16);
    check("R2 mode 10 is level framing", vcount, 2);
    sync_n = 1; wclk(8);

    // edge framing
    mode = 2'b01; wclk(4);
    tx_word = 16'hC0DE; vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'hBEEF, 0, 16); wclk(8);
    check("R7 edge count", vcount, 1);
    check("R7 edge rx word", 32'(vlast), 32'hBEEF);
    check("R4 edge tx word", 32'(got), 32'hC0DE);
    check("R10 edge done with sync low", 32'(dout_en), 0);
    bits(16'hFFFF, 0, 4); wclk(8);
    check("R7 extra clocks ignored", vcount, 1);
    sync_n = 1; wclk(8); sync_n = 0; wclk(4);
    bits(16'h5A5A, 0, 16); wclk(8);
    check("R7 pulse-framed count", vcount, 2);
    check("R7 pulse-framed rx", 32'(vlast), 32'h5A5A);

    // edge framing, sync high mid-frame
    sync_n = 1; wclk(8); sync_n = 0; wclk(4);
    bits(16'h7E81, 0, 8); sync_n = 1; bits(16'h7E81, 8, 8); wclk(8);
    check("R7 sync-high mid-frame count", vcount, 3);
    check("R7 sync-high mid-frame rx", 32'(vlast), 32'h7E81);
    check("R10 enable off with sync high", 32'(dout_en), 0);

    // edge framing restart
    vcount = 0; tx_word = 16'h0F0F;
    sync_n = 0; wclk(4);
    bits(16'h9999, 0, 5);
    tx_word = 16'hE1E1;
    sync_n = 1; wclk(8); sync_n = 0; wclk(4);
    bits(16'h4321, 0, 16); wclk(8);
    check("R8 restart count", vcount, 1);
    check("R8 restart rx", 32'(vlast), 32'h4321);
    check("R8 restart tx reload", 32'(got), 32'hE1E1);
    sync_n = 1; wclk(8);

    // level framing cut short
    mode = 2'b00; wclk(8); vcount = 0;
    sync_n = 0; wclk(4);
    bits(16'hAAAA, 0, 7); wclk(4); sync_n = 1; wclk(8);
    check("R9 short frame no strobe", vcount, 0);
    sync_n = 0; wclk(4);
    bits(16'h2468, 0, 16); wclk(4); sync_n = 1; wclk(8);
    check("R9 next frame count", vcount, 1);
    check("R9 next frame rx", 32'(vlast), 32'h2468);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule